// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a bank of general-purpose input pins (28 by default) and turns selected signal transitions into interrupt requests. Each pin has its own rising-edge enable and its own falling-edge enable. When an enabled transition is seen, the pin's bit in a sticky edge-status register is set. The bit stays set until software writes a 1 to it.

The lowest pins (11 by default) each drive their own request line. The remaining pins are ORed into one summary request. Software reads the status register to find out which of the upper pins fired. Each input passes through a synchronizer before any edge is compared, so pins may be fully asynchronous to the clock.

A sleep input switches the unit to its wake path. While asleep, only pins that are wake-enabled can record edges. The normal request outputs are held low, and a single wake output reports any pending status on a wake-enabled pin. Software reaches the four registers over a simple bus with separate write and read strobes, a word index, and write and read data.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset the edge-status, rising-enable, falling-enable and wake-enable registers all read as zero, and every request output and the wake output are low.
- R2: With a pin's rising enable set (rising-enable register, word index 1, bit n = pin n), a 0-to-1 transition sets status bit n. A rising transition on a pin whose rising enable is clear sets nothing.
- R3: With a pin's falling enable set (falling-enable register, word index 2, bit n = pin n), a 1-to-0 transition sets status bit n. A falling transition on a pin whose falling enable is clear sets nothing.
- R4: With both enables set, a pin records a transition in either direction.
- R5: A set status bit (edge-status register, word index 0) stays set until written with 1. Writing 0 to a bit leaves it unchanged, and writing all ones clears every pending bit.
- R6: When a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: While not asleep, request output irq_pin_o[n] for n in 0..10 equals status bit n.
- R8: While not asleep, irq_summary_o is high exactly when any status bit from 11 to 27 is set.
- R9: While sleep_i is high, only pins whose wake-enable bit is set (word index 3, bit n = pin n) record edges, irq_pin_o and irq_summary_o are low, and wake_o is high exactly when a status bit is set on a wake-enabled pin. wake_o is low while not asleep.
- R10: Bits 31 to 28 of every register read as zero and ignore writes. Word indices other than 0 to 3 read as zero. Read data appears on bus_rdata_o on the clock edge that samples bus_rd_i.
- R11: A pin transition reaches the status register on the third rising clock edge after it is applied: two synchronizer stages, then the status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 28 | Asynchronous input pins |
| sleep_i | input | 1 | High selects the wake path |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_pin_o | output | 11 | One request per low pin |
| irq_summary_o | output | 1 | OR of the upper pins' status |
| wake_o | output | 1 | Wake request while asleep |

## Verification
A wrong synchronizer depth or a wrong edge comparison shows up as a request line that rises one cycle early or late, or that never rises. The latency check pins this to the exact edge. A bad clear path shows up on the next read or the next request sample: a status bit survives an all-ones write, or it drops after a write of 0. Faulty sleep gating appears at once on wake_o, or as a request line that stays high while asleep. Writes and reads of the unused upper bits show any leak on the very next read.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int REG_IDX_W = 4;

   // Register word indices on the bus
   typedef enum logic [REG_IDX_W-1:0] {
      REG_STATUS = 4'd0,
      REG_RISE   = 4'd1,
      REG_FALL   = 4'd2,
      REG_WAKE   = 4'd3
   } reg_idx_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int NUM_PINS    = 28,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] fall_o
);

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[SYNC_STAGES-1];
   end

   assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;
   assign fall_o = ~stage_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS = 28,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic                sleep_i,
   input  logic [NUM_PINS-1:0] rise_evt_i,
   input  logic [NUM_PINS-1:0] fall_evt_i,
   output logic [NUM_PINS-1:0] status_o,
   output logic [NUM_PINS-1:0] rise_en_o,
   output logic [NUM_PINS-1:0] fall_en_o,
   output logic [NUM_PINS-1:0] wake_en_o
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   logic [NUM_PINS-1:0] status_q, rise_en_q, fall_en_q, wake_en_q;
   logic [NUM_PINS-1:0] wr_bits, clr_mask, set_mask, gate;
   logic                hit_status, hit_rise, hit_fall, hit_wake;
   logic [NUM_PINS-1:0] rd_bits;

   assign wr_bits    = wdata_i[NUM_PINS-1:0];
   assign hit_status = wr_i && (addr_i == ADDR_W'(REG_STATUS));
   assign hit_rise   = wr_i && (addr_i == ADDR_W'(REG_RISE));
   assign hit_fall   = wr_i && (addr_i == ADDR_W'(REG_FALL));
   assign hit_wake   = wr_i && (addr_i == ADDR_W'(REG_WAKE));

   // While asleep only wake-enabled pins may record edges
   assign gate     = sleep_i ? wake_en_q : '1;
   assign set_mask = ((rise_evt_i & rise_en_q) | (fall_evt_i & fall_en_q)) & gate;
   assign clr_mask = hit_status ? wr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         wake_en_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_mask) | set_mask;
         if (hit_rise) rise_en_q <= wr_bits;
         if (hit_fall) fall_en_q <= wr_bits;
         if (hit_wake) wake_en_q <= wr_bits;
      end
   end

   always_comb begin
      case (addr_i)
         ADDR_W'(REG_STATUS): rd_bits = status_q;
         ADDR_W'(REG_RISE):   rd_bits = rise_en_q;
         ADDR_W'(REG_FALL):   rd_bits = fall_en_q;
         ADDR_W'(REG_WAKE):   rd_bits = wake_en_q;
         default:             rd_bits = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= {{PAD_W{1'b0}}, rd_bits};
   end

   assign status_o  = status_q;
   assign rise_en_o = rise_en_q;
   assign fall_en_o = fall_en_q;
   assign wake_en_o = wake_en_q;

endmodule

// File: rtl/gpio_edge_outs.sv
module gpio_edge_outs #(
   parameter int NUM_PINS   = 28,
   parameter int NUM_DIRECT = 11
) (
   input  logic [NUM_PINS-1:0]   status_i,
   input  logic [NUM_PINS-1:0]   wake_en_i,
   input  logic                  sleep_i,
   output logic [NUM_DIRECT-1:0] irq_pin_o,
   output logic                  irq_summary_o,
   output logic                  wake_o
);

   logic upper_any;

   generate
      for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
         assign irq_pin_o[i] = status_i[i] & ~sleep_i;
      end
      if (NUM_DIRECT < NUM_PINS) begin : g_cascade
         assign upper_any = |status_i[NUM_PINS-1:NUM_DIRECT];
      end else begin : g_no_cascade
         assign upper_any = 1'b0;
      end
   endgenerate

   assign irq_summary_o = upper_any & ~sleep_i;
   assign wake_o        = sleep_i & |(status_i & wake_en_i);

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS    = 28,
   parameter int NUM_DIRECT  = 11,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = REG_IDX_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_i,
   input  logic                  sleep_i,
   input  logic                  bus_wr_i,
   input  logic                  bus_rd_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [DATA_W-1:0]     bus_wdata_i,
   output logic [DATA_W-1:0]     bus_rdata_o,
   output logic [NUM_DIRECT-1:0] irq_pin_o,
   output logic                  irq_summary_o,
   output logic                  wake_o
);

   generate
      if (NUM_PINS > DATA_W || NUM_PINS < 1) begin : g_bad_pins
         $error("NUM_PINS must lie between 1 and DATA_W");
      end
      if (NUM_DIRECT < 1 || NUM_DIRECT > NUM_PINS) begin : g_bad_direct
         $error("NUM_DIRECT must lie between 1 and NUM_PINS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < REG_IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register indices");
      end
   endgenerate

   logic [NUM_PINS-1:0] rise_evt, fall_evt;
   logic [NUM_PINS-1:0] status_q, rise_en_q, fall_en_q, wake_en_q;

   gpio_edge_sync #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise_evt),
      .fall_o (fall_evt)
   );

   gpio_edge_regs #(
      .NUM_PINS (NUM_PINS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr_i),
      .rd_i       (bus_rd_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (bus_rdata_o),
      .sleep_i    (sleep_i),
      .rise_evt_i (rise_evt),
      .fall_evt_i (fall_evt),
      .status_o   (status_q),
      .rise_en_o  (rise_en_q),
      .fall_en_o  (fall_en_q),
      .wake_en_o  (wake_en_q)
   );

   gpio_edge_outs #(
      .NUM_PINS   (NUM_PINS),
      .NUM_DIRECT (NUM_DIRECT)
   ) outs_i (
      .status_i      (status_q),
      .wake_en_i     (wake_en_q),
      .sleep_i       (sleep_i),
      .irq_pin_o     (irq_pin_o),
      .irq_summary_o (irq_summary_o),
      .wake_o        (wake_o)
   );

endmodule

// File: rtl/gpio_edge_irq_unit_chk.sv
module gpio_edge_irq_unit_chk #(
   parameter int NUM_PINS   = 28,
   parameter int NUM_DIRECT = 11,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sleep_i,
   input logic                  bus_wr_i,
   input logic [ADDR_W-1:0]     bus_addr_i,
   input logic [DATA_W-1:0]     bus_wdata_i,
   input logic [DATA_W-1:0]     bus_rdata_o,
   input logic [NUM_DIRECT-1:0] irq_pin_o,
   input logic                  irq_summary_o,
   input logic                  wake_o,
   input logic [NUM_PINS-1:0]   status_q,
   input logic [NUM_PINS-1:0]   rise_en_q,
   input logic [NUM_PINS-1:0]   fall_en_q,
   input logic [NUM_PINS-1:0]   wake_en_q
);

   logic [NUM_PINS-1:0] keep_q;

   // Bits that must still be set next cycle: set now and not written with 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) keep_q <= '0;
      else keep_q <= status_q & ~((bus_wr_i && bus_addr_i == '0) ? bus_wdata_i[NUM_PINS-1:0] : '0);
   end

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & keep_q) == keep_q)); // R5

   AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_en_q | fall_en_q)) == '0)); // R2

   AST_SLEEP_NEEDS_WAKE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> ((status_q & ~$past(status_q) & ~$past(wake_en_q)) == '0)); // R9

   AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |-> (irq_pin_o == status_q[NUM_DIRECT-1:0])); // R7

   AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |-> (irq_summary_o == |status_q[NUM_PINS-1:NUM_DIRECT])); // R8

   AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (irq_pin_o == '0 && !irq_summary_o)); // R9

   AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> sleep_i); // R9

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata_o[DATA_W-1:NUM_PINS] == '0)); // R10

endmodule

bind gpio_edge_irq_unit gpio_edge_irq_unit_chk #(
   .NUM_PINS   (NUM_PINS),
   .NUM_DIRECT (NUM_DIRECT),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep_i       (sleep_i),
   .bus_wr_i      (bus_wr_i),
   .bus_addr_i    (bus_addr_i),
   .bus_wdata_i   (bus_wdata_i),
   .bus_rdata_o   (bus_rdata_o),
   .irq_pin_o     (irq_pin_o),
   .irq_summary_o (irq_summary_o),
   .wake_o        (wake_o),
   .status_q      (status_q),
   .rise_en_q     (rise_en_q),
   .fall_en_q     (fall_en_q),
   .wake_en_q     (wake_en_q)
);

// File: tb/gpio_edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit_tb_top;

   localparam int NP = 28;
   localparam int ND = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic          sleep = 1'b0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [3:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [ND-1:0] irq_pin;
   logic          irq_sum, wake;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   gpio_edge_irq_unit dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .pin_i         (pins),
      .sleep_i       (sleep),
      .bus_wr_i      (wr),
      .bus_rd_i      (rd),
      .bus_addr_i    (addr),
      .bus_wdata_i   (wdata),
      .bus_rdata_o   (rdata),
      .irq_pin_o     (irq_pin),
      .irq_summary_o (irq_sum),
      .wake_o        (wake)
   );

   // Vectors: {start pins, end pins, rise enables, fall enables}
   localparam logic [4*NP-1:0] VEC [4] = '{
      {28'h0000000, 28'h0000FFF, 28'h0000F0F, 28'hFFFFFFF},   // R2
      {28'hFFFFFFF, 28'hFFFF000, 28'hFFFFFFF, 28'h00000F0},   // R3
      {28'h00FF00F, 28'h0F0F0F0, 28'hFFFFFFF, 28'hFFFFFFF},   // R4
      {28'h0000000, 28'hFFFF800, 28'h8000000, 28'h0000000}    // R8
   };
   localparam logic [NP-1:0] EXP [4] = '{
      28'h0000F0F, 28'h00000F0, 28'h0FF00FF, 28'h8000000
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      tick(3);
      // R1: reset state
      check("R1 irq", {20'd0, irq_pin, irq_sum}, 32'd0);
      check("R1 wake", {31'd0, wake}, 32'd0);
      rst_n = 1'b1;
      tick(2);
      for (int a = 0; a < 4; a++) begin
         bus_read(4'(a), r);
         check("R1 reg", r, 32'd0);
      end

      // Table walk: R2 R3 R4 R7 R8
      for (int v = 0; v < 4; v++) begin
         bus_write(4'd1, 32'd0);
         bus_write(4'd2, 32'd0);
         pins = VEC[v][4*NP-1:3*NP];
         tick(4);
         bus_write(4'd0, 32'hFFFF_FFFF);
         bus_write(4'd1, {4'd0, VEC[v][2*NP-1:NP]});
         bus_write(4'd2, {4'd0, VEC[v][NP-1:0]});
         pins = VEC[v][3*NP-1:2*NP];
         tick(3);
         bus_read(4'd0, r);
         check("R2/R3/R4 status", r, {4'd0, EXP[v]});
         check("R7 direct", {21'd0, irq_pin}, {21'd0, EXP[v][ND-1:0]});
         check("R8 summary", {31'd0, irq_sum}, {31'd0, |EXP[v][NP-1:ND]});
      end

      // R5: write 0 keeps, write 1 clears (status holds bit 27 from last vector)
      bus_write(4'd0, 32'h0000_0000);
      bus_read(4'd0, r);
      check("R5 write0 keeps", r, 32'h0800_0000);
      bus_write(4'd0, 32'h0800_0000);
      bus_read(4'd0, r);
      check("R5 write1 clears", r, 32'd0);
      check("R5 summary drops", {31'd0, irq_sum}, 32'd0);

      // R11: latency of exactly three rising edges
      bus_write(4'd2, 32'd0);
      bus_write(4'd1, 32'h0000_0021);
      pins = '0;
      tick(4);
      bus_write(4'd0, 32'hFFFF_FFFF);
      pins[5] = 1'b1;
      tick(2);
      check("R11 not before third edge", {31'd0, irq_pin[5]}, 32'd0);
      tick(1);
      check("R11 on third edge", {31'd0, irq_pin[5]}, 32'd1);

      // R5: all ones clears several pending bits
      pins[0] = 1'b1;
      tick(3);
      check("R5 two pending", {21'd0, irq_pin}, 32'h0000_0021);
      bus_write(4'd0, 32'hFFFF_FFFF);
      check("R5 all ones clears", {21'd0, irq_pin}, 32'd0);

      // R6: edge and clear on pin 0 in the same cycle
      pins[0] = 1'b0;
      tick(4);
      bus_write(4'd0, 32'hFFFF_FFFF);
      pins[0] = 1'b1;
      tick(1);
      bus_write(4'd0, 32'h0000_0001);
      bus_read(4'd0, r);
      check("R6 edge wins", r, 32'd0);
      // the write above landed one edge before; redo aligned with the set edge
      pins[0] = 1'b0;
      tick(4);
      bus_write(4'd0, 32'h0000_0001);
      check("R6 pre-set bit", {31'd0, irq_pin[0]}, 32'd0);
      bus_write(4'd1, 32'h0000_0001);
      pins[0] = 1'b1;
      tick(2);
      bus_write(4'd0, 32'h0000_0001);
      check("R6 edge beats clear", {31'd0, irq_pin[0]}, 32'd1);
      bus_write(4'd0, 32'h0000_0001);
      check("R6 later clear works", {31'd0, irq_pin[0]}, 32'd0);

      // R9: sleep path
      pins = '0;
      bus_write(4'd1, 32'h0000_0006);
      bus_write(4'd3, 32'h0000_0002);
      tick(4);
      bus_write(4'd0, 32'hFFFF_FFFF);
      sleep = 1'b1;
      tick(1);
      check("R9 wake idle", {31'd0, wake}, 32'd0);
      pins[1] = 1'b1; pins[2] = 1'b1;
      tick(3);
      bus_read(4'd0, r);
      check("R9 only wake pins record", r, 32'h0000_0002);
      check("R9 irq quiet asleep", {21'd0, irq_pin}, 32'd0);
      check("R9 wake high", {31'd0, wake}, 32'd1);
      sleep = 1'b0;
      tick(1);
      check("R9 wake low awake", {31'd0, wake}, 32'd0);
      check("R9 irq after sleep", {21'd0, irq_pin}, 32'h0000_0002);

      // R10: upper bits and unmapped indices
      bus_write(4'd3, 32'hFFFF_FFFF);
      bus_read(4'd3, r);
      check("R10 upper bits zero", r, 32'h0FFF_FFFF);
      bus_read(4'd7, r);
      check("R10 unmapped zero", r, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule